// File: doc/BRIEF.md
# Virtual Page-Load Scan Chain

This block is a test data register that a boundary-scan host sees as one long scan chain, as long as a whole memory page. Inside there is only a byte-wide shift register, a bit counter and a byte address. While the register is selected and the TAP is in Shift-DR, bits from TDI enter the shift register least significant bit first. Each time eight bits have arrived, the assembled byte goes out on a byte-wide write port to an external page buffer, and the byte address steps on by one. The host can then stream a full page in a single Shift-DR pass without a page-sized shift register.

Update-DR plays no part: the transfers happen while shifting. Capture-DR rewinds the chain to page byte 0 and drops any partly assembled byte. Once the last byte of the page has been written, the address stays where it is and no further writes are issued until the next Capture-DR. TDO carries the bits from TDI delayed by eight shift cycles. The chain behaves as intended only when this device sits first on the scan chain, because the bytes are taken directly from the TDI pin.

Top module: `vpl_chain`

## Requirements
- R1: After reset the write strobe `pg_wr` is low and `tdo` is 0.
- R2: Each written byte holds the eight bits shifted in since the previous byte boundary, least significant bit first: bit i of `pg_data` is the i-th of those eight bits.
- R3: `pg_wr` is high for exactly one clock cycle, the cycle that follows the clock edge on which the eighth bit of a byte is shifted.
- R4: The first byte after a Capture-DR is written to address 0, and each later byte goes to the next higher address.
- R5: Capture-DR with the register selected resets the byte address to 0 and the bit count to 0, so a partly shifted byte is discarded.
- R6: Update-DR has no effect: it causes no write and does not disturb the byte being assembled.
- R7: With the default page of 1024 bits (128 bytes), the chain writes at most 128 bytes after a Capture-DR, at addresses 0 to 127. Any further bytes produce no write.
- R8: Shift cycles are counted only while `sel` and `shift_dr` are both high. Cycles with either of them low neither advance the bit count nor shift the register, so pauses inside a byte do not change its value.
- R9: During a counted shift cycle, `tdo` shows the bit that was shifted in eight counted shift cycles earlier, or 0 if fewer than eight have occurred since reset or the last Capture-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | High while the page-load instruction is current |
| capture_dr | input | 1 | TAP is in Capture-DR |
| shift_dr | input | 1 | TAP is in Shift-DR |
| update_dr | input | 1 | TAP is in Update-DR; has no effect |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, TDI delayed by eight shift cycles |
| pg_wr | output | 1 | One-cycle write strobe to the page buffer |
| pg_addr | output | 7 | Byte address within the page |
| pg_data | output | 8 | Assembled byte |

## Verification
Write results are registered once. A byte whose eighth bit is shifted on a rising edge therefore shows up on `pg_wr`, `pg_addr` and `pg_data` at the next falling edge, and they hold there for that one cycle only. The bench changes inputs and samples `tdo` on falling edges. A monitor, also running on falling edges, matches each strobe against the head of a queue that the driver fills from its own model at the moment it shifts an eighth bit. A strobe seen on two falling edges in a row, a strobe with no queued entry, or an entry still in the queue at the end all count as failures. `tdo` is compared before the edge that shifts the current bit, against a history of the bits driven since the last capture.

// File: rtl/vpl_pkg.sv
package vpl_pkg;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_CLEAR = 2'd1,
        OP_SHIFT = 2'd2
    } scan_op_e;

    // Capture takes precedence; nothing happens unless the register is selected.
    function automatic scan_op_e decode_op(input logic sel_i,
                                           input logic cap_i,
                                           input logic sh_i);
        scan_op_e op;
        if (!sel_i)     op = OP_HOLD;
        else if (cap_i) op = OP_CLEAR;
        else if (sh_i)  op = OP_SHIFT;
        else            op = OP_HOLD;
        return op;
    endfunction

endpackage

// File: rtl/vpl_bit_counter.sv
module vpl_bit_counter
    import vpl_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic     clk,
    input  logic     rst_n,
    input  scan_op_e op,
    output logic     byte_done
);
    localparam int CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        byte_done = 1'b0;
        case (op)
            OP_CLEAR: st_d.cnt = '0;
            OP_SHIFT: begin
                byte_done = (st_q.cnt == LAST);
                st_d.cnt  = byte_done ? '0 : st_q.cnt + 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SHIFT && st_q.cnt != LAST) |=> (st_q.cnt == $past(st_q.cnt) + 1'b1)); // R8
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_HOLD) |=> $stable(st_q.cnt)); // R8

endmodule

// File: rtl/vpl_byte_addr.sv
module vpl_byte_addr
    import vpl_pkg::*;
#(
    parameter int PAGE_BYTES = 128
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  scan_op_e                      op,
    input  logic                          advance,
    output logic [$clog2(PAGE_BYTES)-1:0] addr,
    output logic                          full
);
    localparam int ADDR_W = $clog2(PAGE_BYTES);
    localparam logic [ADDR_W-1:0] TOP = ADDR_W'(PAGE_BYTES - 1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              full;
    } addr_state_t;

    addr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (op == OP_CLEAR) begin
            st_d.addr = '0;
            st_d.full = 1'b0;
        end else if (advance && !st_q.full) begin
            if (st_q.addr == TOP) st_d.full = 1'b1;
            else                  st_d.addr = st_q.addr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr = st_q.addr;
    assign full = st_q.full;

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (op != OP_CLEAR && advance && !st_q.full && st_q.addr != TOP)
            |=> (st_q.addr == $past(st_q.addr) + 1'b1)); // R4
    AST_ADDR_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CLEAR) |=> (st_q.addr == '0 && !st_q.full)); // R5
    AST_ADDR_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.full && op != OP_CLEAR) |=> $stable(st_q.addr)); // R7

endmodule

// File: rtl/vpl_chain.sv
module vpl_chain
    import vpl_pkg::*;
#(
    parameter int PAGE_BITS = 1024,
    parameter int BYTE_W    = 8
) (
    input  logic                                   tck,
    input  logic                                   rst_n,
    input  logic                                   sel,
    input  logic                                   capture_dr,
    input  logic                                   shift_dr,
    input  logic                                   update_dr,
    input  logic                                   tdi,
    output logic                                   tdo,
    output logic                                   pg_wr,
    output logic [$clog2(PAGE_BITS/BYTE_W)-1:0]    pg_addr,
    output logic [BYTE_W-1:0]                      pg_data
);
    localparam int PAGE_BYTES = PAGE_BITS / BYTE_W;
    localparam int ADDR_W     = $clog2(PAGE_BYTES);

    typedef struct packed {
        logic [BYTE_W-1:0] sh;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } chain_state_t;

    chain_state_t st_d, st_q;
    scan_op_e     op;
    logic         byte_done;
    logic [ADDR_W-1:0] cur_addr;
    logic         page_full;
    logic [BYTE_W-1:0] sh_next;

    assign op = decode_op(sel, capture_dr, shift_dr);

    vpl_bit_counter #(.BYTE_W(BYTE_W)) u_bits (
        .clk       (tck),
        .rst_n     (rst_n),
        .op        (op),
        .byte_done (byte_done)
    );

    vpl_byte_addr #(.PAGE_BYTES(PAGE_BYTES)) u_addr (
        .clk     (tck),
        .rst_n   (rst_n),
        .op      (op),
        .advance (byte_done),
        .addr    (cur_addr),
        .full    (page_full)
    );

    // New bits enter at the top, so the first bit of a byte lands in bit 0.
    assign sh_next = {tdi, st_q.sh[BYTE_W-1:1]};

    always_comb begin
        st_d    = st_q;
        st_d.wr = 1'b0;
        case (op)
            OP_CLEAR: st_d.sh = '0;
            OP_SHIFT: begin
                st_d.sh = sh_next;
                if (byte_done && !page_full) begin
                    st_d.wr   = 1'b1;
                    st_d.addr = cur_addr;
                    st_d.data = sh_next;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tdo     = st_q.sh[0];
    assign pg_wr   = st_q.wr;
    assign pg_addr = st_q.addr;
    assign pg_data = st_q.data;

    AST_WR_SINGLE: assert property (@(posedge tck) disable iff (!rst_n)
        pg_wr |=> !pg_wr); // R3
    AST_NO_WR_WHEN_FULL: assert property (@(posedge tck) disable iff (!rst_n)
        (page_full && !(sel && capture_dr)) |=> !pg_wr); // R7
    AST_UPDATE_INERT: assert property (@(posedge tck) disable iff (!rst_n)
        (sel && update_dr && !shift_dr && !capture_dr) |=> (!pg_wr && $stable(st_q.sh))); // R6
    AST_WR_NEEDS_SHIFT: assert property (@(posedge tck) disable iff (!rst_n)
        !(sel && shift_dr && !capture_dr) |=> !pg_wr); // R8

endmodule

// File: tb/tb_vpl_chain.sv
module tb_vpl_chain;

    logic       tck = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel = 1'b0, capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, tdi = 1'b0;
    logic       tdo, pg_wr;
    logic [6:0] pg_addr;
    logic [7:0] pg_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Expected writes: {addr, data}
    logic [14:0] exp_q[$];
    // Bench model
    logic       hist[$];
    int         m_bits = 0;
    int         m_addr = 0;
    bit         m_full = 1'b0;
    logic [7:0] m_cur = '0;

    always #10 tck = ~tck;  // 50 MHz

    vpl_chain dut (
        .tck(tck), .rst_n(rst_n), .sel(sel), .capture_dr(capture_dr),
        .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi), .tdo(tdo),
        .pg_wr(pg_wr), .pg_addr(pg_addr), .pg_data(pg_data)
    );

    // Monitor: compares strobes with the queue, on falling edges
    bit prev_wr = 1'b0;
    always @(negedge tck) begin
        if (rst_n && !done) begin
            if (pg_wr && prev_wr) begin
                checks++; errors++;
                $display("FAIL R3 strobe high two cycles: actual 1 expected 0");
            end
            if (pg_wr) begin
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R7 unexpected write: actual addr %0d data %02h expected none",
                             pg_addr, pg_data);
                end else begin
                    logic [14:0] e;
                    e = exp_q.pop_front();
                    if ({pg_addr, pg_data} !== e) begin
                        errors++;
                        $display("FAIL R2/R4 write: actual addr %0d data %02h expected addr %0d data %02h",
                                 pg_addr, pg_data, e[14:8], e[7:0]);
                    end
                end
            end
            prev_wr = pg_wr;
        end
    end

    task automatic model_clear();
        m_bits = 0; m_addr = 0; m_full = 1'b0; m_cur = '0;
        hist.delete();
    endtask

    // One cycle with the given controls; checks tdo for counted shift cycles (R9)
    task automatic cycle(input logic s, input logic cap, input logic sh,
                         input logic upd, input logic b);
        @(negedge tck);
        sel = s; capture_dr = cap; shift_dr = sh; update_dr = upd; tdi = b;
        #1;
        if (s && cap) model_clear();
        else if (s && sh) begin
            logic exp_tdo;
            exp_tdo = (hist.size() >= 8) ? hist[hist.size() - 8] : 1'b0;
            checks++;
            if (tdo !== exp_tdo) begin
                errors++;
                $display("FAIL R9 tdo: actual %0b expected %0b", tdo, exp_tdo);
            end
            hist.push_back(b);
            m_cur = {b, m_cur[7:1]};
            m_bits++;
            if (m_bits == 8) begin
                m_bits = 0;
                if (!m_full) begin
                    exp_q.push_back({7'(m_addr), m_cur});
                    if (m_addr == 127) m_full = 1'b1;
                    else m_addr++;
                end
            end
        end
        @(posedge tck);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic capture();
        cycle(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic shift_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) cycle(1'b1, 1'b0, 1'b1, 1'b0, v[i]);
    endtask

    task automatic drain(input string tag);
        idle(3);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL %s missing writes: actual pending %0d expected 0", tag, exp_q.size());
        end
    endtask

    initial begin
        // R1: reset state
        #5;
        checks++;
        if (pg_wr !== 1'b0 || tdo !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: actual wr %0b tdo %0b expected 0 0", pg_wr, tdo);
        end
        repeat (3) @(posedge tck);
        @(negedge tck); rst_n = 1'b1;
        idle(2);
        checks++;
        if (pg_wr !== 1'b0 || tdo !== 1'b0) begin
            errors++;
            $display("FAIL R1 after reset: actual wr %0b tdo %0b expected 0 0", pg_wr, tdo);
        end

        // R2 R4 R9: several bytes from address 0
        capture();
        shift_byte(8'hA5); shift_byte(8'h3C); shift_byte(8'h01); shift_byte(8'h80);
        drain("R4");

        // R8: pauses and deselected shifting inside a byte
        capture();
        for (int i = 0; i < 4; i++) cycle(1'b0, 1'b0, 1'b1, 1'b0, 1'b1); // sel low: ignored
        for (int i = 0; i < 8; i++) begin
            cycle(1'b1, 1'b0, 1'b1, 1'b0, i[0]);
            if (i == 3) idle(2);
            if (i == 5) cycle(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);   // selected, no shift
        end
        drain("R8");

        // R6: update pulse mid-byte
        capture();
        for (int i = 0; i < 3; i++) cycle(1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
        cycle(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R6 model state: actual pending %0d expected 0", exp_q.size());
        end
        for (int i = 0; i < 5; i++) cycle(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        drain("R6");

        // R5: capture discards a partial byte and rewinds
        shift_byte(8'h11);
        for (int i = 0; i < 5; i++) cycle(1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
        capture();
        shift_byte(8'h77);
        drain("R5");

        // R7: full page plus two extra bytes
        capture();
        for (int k = 0; k < 130; k++) shift_byte(8'((k * 37 + 5) & 8'hFF));
        drain("R7");
        checks++;
        if (!m_full) begin
            errors++;
            $display("FAIL R7 model: actual not full expected full");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge tck);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule